// File: doc/BRIEF.md
# 16-bit Parallel Display Bus Master (8080 style)

This block sits on the host side of a 16-bit, 8080-style parallel link to a small TFT display controller. Upstream logic hands it one transfer at a time over a valid/ready request port: a command write, a data write, an identification read or a frame-memory read. The block produces the chip-select, register-select, write-strobe and read-strobe lines, drives the outgoing half of the data bus with a separate output enable, and returns read words on a response port as a one-cycle pulse.

Every strobe phase is a whole number of system clock cycles. These counts are derived from nanosecond limits by ceiling division against a clock-period parameter, so the same code meets the bus timing at any clock rate. The two read kinds use different timing profiles. A frame-memory read is several times slower than an identification read.

After its own synchronous reset, the block pulses the display's active-low reset line. It then refuses all transfers until the command lockout has elapsed. A request flagged as the sleep-exit command must wait for a second, much longer lockout. Consecutive requests of the same kind run back to back with chip select held low.

Top module: `disp8080_master`

## Requirements
- R1: While `rst` is high and until `lcd_rst_n` rises, chip select, both strobes and `req_ready` are inactive and the output enable is low. `lcd_rst_n` stays low for at least ceil(`RST_LOW_NS`/`CLK_NS`) cycles after `rst` falls.
- R2: No request is accepted sooner than ceil(`CMD_WAIT_NS`/`CLK_NS`) cycles after `lcd_rst_n` rises. An unflagged command is accepted within 3 cycles of that point.
- R3: A request with `req_sleep_out`=1 is held off with `req_ready` low until at least ceil(`SLP_WAIT_NS`/`CLK_NS`) cycles after `lcd_rst_n` rises.
- R4: `lcd_dc` is 0 for a command write (`req_kind`=0) and 1 for a data write (1), an identification read (2) and a frame-memory read (3). It is stable while a strobe is low.
- R5: For writes, `lcd_wr_n` stays low for at least max(ceil(15 ns), ceil(10 ns)) cycles and high for at least ceil(15 ns) cycles between strobes. Falling edges are at least ceil(66 ns) cycles apart. `lcd_db_out` carries `req_wdata` with `lcd_db_oe` high, unchanged, while the strobe is low.
- R6: Chip select falls at least ceil(15 ns), ceil(45 ns) or ceil(355 ns) cycles before the first strobe of a write, an identification read or a frame-memory read respectively. It rises no sooner than ceil(10 ns) cycles after the last strobe rises. Strobes fall only with chip select low.
- R7: An identification read holds `lcd_rd_n` low for at least ceil(45 ns) cycles and high for at least ceil(90 ns) cycles, with falling edges at least ceil(160 ns) cycles apart. Data is sampled more than 40 ns after the strobe falls.
- R8: A frame-memory read holds `lcd_rd_n` low for at least ceil(355 ns) cycles and high for at least ceil(90 ns) cycles, with falling edges at least ceil(450 ns) cycles apart. Data is sampled more than 340 ns after the strobe falls.
- R9: `lcd_db_oe` is high only for writes. It is low in the cycle before and during every read strobe, and the two strobes are never low together.
- R10: Each read yields exactly one `rsp_valid` pulse, one cycle long, in the cycle `lcd_rd_n` rises, with `rsp_rdata` equal to the sampled bus word. Writes yield none.
- R11: A request of the same kind arriving while a transfer is in progress keeps chip select low across both transfers. A request of a different kind makes chip select rise between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_kind | input | 2 | 0 command write, 1 data write, 2 identification read, 3 frame-memory read |
| req_sleep_out | input | 1 | Marks the request as the sleep-exit command |
| req_wdata | input | DW | Word to write |
| rsp_valid | output | 1 | One-cycle pulse with read result |
| rsp_rdata | output | DW | Read result |
| lcd_rst_n | output | 1 | Display hardware reset, active low |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_dc | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_db_out | output | DW | Outgoing data bus value |
| lcd_db_oe | output | 1 | Output enable for the data bus pads |
| lcd_db_in | input | DW | Incoming data bus value |

## Verification
The bench's display model drives a wrong word on the bus for the whole access time after each read strobe falls. A read phase that is too short therefore returns the wrong word instead of slipping through. Lockout timing is measured from the release of the display reset. A design that ignored the sleep-exit flag would accept that command hundreds of cycles early, and one that counted from the wrong point would miss the three-cycle window for ordinary commands. Pairs of same-kind and mixed-kind requests expose a chip select that drops between chained transfers or stays low across a change of direction. Mixed random traffic catches an output enable left on into a following read.

// File: rtl/disp8080_pkg.sv
package disp8080_pkg;

  localparam logic [1:0] K_CMD  = 2'd0;
  localparam logic [1:0] K_DATA = 2'd1;
  localparam logic [1:0] K_IDRD = 2'd2;
  localparam logic [1:0] K_FMRD = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_LOW,
    S_HIGH,
    S_HOLD
  } bus_state_e;

  // ceiling division of a time limit into clock cycles, never below one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/disp_reset_seq.sv
module disp_reset_seq #(
  parameter int RST_CYC = 2000,
  parameter int CMD_CYC = 1000000,
  parameter int SLP_CYC = 24000000
) (
  input  logic clk,
  input  logic rst,
  output logic lcd_rst_n,
  output logic cmd_ok,
  output logic slp_ok
);
  localparam int TOTAL = RST_CYC + SLP_CYC;
  localparam int TW    = $clog2(TOTAL + 1);

  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick      <= '0;
      lcd_rst_n <= 1'b0;
      cmd_ok    <= 1'b0;
      slp_ok    <= 1'b0;
    end else begin
      if (tick != TW'(TOTAL)) tick <= tick + 1'b1;
      lcd_rst_n <= (tick >= TW'(RST_CYC));
      cmd_ok    <= (tick >= TW'(RST_CYC + CMD_CYC));
      slp_ok    <= (tick >= TW'(TOTAL));
    end
  end

endmodule

// File: rtl/disp_xfer_engine.sv
module disp_xfer_engine
  import disp8080_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SU_WR = 3,
  parameter int LO_WR = 3,
  parameter int HI_WR = 11,
  parameter int SU_ID = 9,
  parameter int LO_ID = 9,
  parameter int HI_ID = 23,
  parameter int SU_FM = 71,
  parameter int LO_FM = 71,
  parameter int HI_FM = 19,
  parameter int HOLD  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_ok,
  input  logic          slp_ok,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_sleep_out,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          cs_n,
  output logic          dc,
  output logic          wr_n,
  output logic          rd_n,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  input  logic [DW-1:0] db_in
);
  localparam int MAXLEN = max2(max2(max2(SU_WR, SU_ID), max2(SU_FM, HOLD)),
                               max2(max2(max2(LO_WR, HI_WR), max2(LO_ID, HI_ID)),
                                    max2(LO_FM, HI_FM)));
  localparam int CW = $clog2(MAXLEN + 1);

  function automatic logic [CW-1:0] su_m1(input logic [1:0] k);
    case (k)
      K_IDRD:  return CW'(SU_ID - 1);
      K_FMRD:  return CW'(SU_FM - 1);
      default: return CW'(SU_WR - 1);
    endcase
  endfunction

  function automatic logic [CW-1:0] lo_m1(input logic [1:0] k);
    case (k)
      K_IDRD:  return CW'(LO_ID - 1);
      K_FMRD:  return CW'(LO_FM - 1);
      default: return CW'(LO_WR - 1);
    endcase
  endfunction

  function automatic logic [CW-1:0] hi_m1(input logic [1:0] k);
    case (k)
      K_IDRD:  return CW'(HI_ID - 1);
      K_FMRD:  return CW'(HI_FM - 1);
      default: return CW'(HI_WR - 1);
    endcase
  endfunction

  bus_state_e    st;
  logic [CW-1:0] cnt;
  logic [1:0]    cur_kind;
  logic          gate_ok, chain_pt, accept;

  assign gate_ok   = cmd_ok && (!req_sleep_out || slp_ok);
  assign chain_pt  = (st == S_HIGH) && (cnt == '0) && (req_kind == cur_kind);
  assign req_ready = gate_ok && ((st == S_IDLE) || chain_pt);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      cur_kind  <= K_CMD;
      cs_n      <= 1'b1;
      dc        <= 1'b0;
      wr_n      <= 1'b1;
      rd_n      <= 1'b1;
      db_out    <= '0;
      db_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            cur_kind <= req_kind;
            cs_n     <= 1'b0;
            dc       <= (req_kind != K_CMD);
            db_out   <= req_wdata;
            db_oe    <= !req_kind[1];
            cnt      <= su_m1(req_kind);
            st       <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (cnt == '0) begin
            if (cur_kind[1]) rd_n <= 1'b0;
            else             wr_n <= 1'b0;
            cnt <= lo_m1(cur_kind);
            st  <= S_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_LOW: begin
          if (cnt == '0) begin
            wr_n <= 1'b1;
            rd_n <= 1'b1;
            if (cur_kind[1]) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= db_in;
            end
            cnt <= hi_m1(cur_kind);
            st  <= S_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HIGH: begin
          if (cnt == '0) begin
            if (accept) begin
              db_out <= req_wdata;
              if (cur_kind[1]) rd_n <= 1'b0;
              else             wr_n <= 1'b0;
              cnt <= lo_m1(cur_kind);
              st  <= S_LOW;
            end else begin
              db_oe <= 1'b0;
              cnt   <= CW'(HOLD - 1);
              st    <= S_HOLD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == '0) begin
            cs_n <= 1'b1;
            st   <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/disp8080_master.sv
module disp8080_master
  import disp8080_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CLK_NS      = 5,
  parameter int RST_LOW_NS  = 10000,
  parameter int CMD_WAIT_NS = 5000000,
  parameter int SLP_WAIT_NS = 120000000,
  parameter int WR_CS_NS    = 15,
  parameter int WR_LO_NS    = 15,
  parameter int WR_HI_NS    = 15,
  parameter int WR_CYC_NS   = 66,
  parameter int WR_DSU_NS   = 10,
  parameter int WR_DH_NS    = 10,
  parameter int ID_CS_NS    = 45,
  parameter int ID_LO_NS    = 45,
  parameter int ID_HI_NS    = 90,
  parameter int ID_CYC_NS   = 160,
  parameter int ID_ACC_NS   = 40,
  parameter int FM_CS_NS    = 355,
  parameter int FM_LO_NS    = 355,
  parameter int FM_HI_NS    = 90,
  parameter int FM_CYC_NS   = 450,
  parameter int FM_ACC_NS   = 340,
  parameter int CS_HOLD_NS  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_sleep_out,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          lcd_rst_n,
  output logic          lcd_cs_n,
  output logic          lcd_dc,
  output logic          lcd_wr_n,
  output logic          lcd_rd_n,
  output logic [DW-1:0] lcd_db_out,
  output logic          lcd_db_oe,
  input  logic [DW-1:0] lcd_db_in
);
  localparam int RST_CYC = ns2cyc(RST_LOW_NS, CLK_NS);
  localparam int CMD_CYC = ns2cyc(CMD_WAIT_NS, CLK_NS);
  localparam int SLP_CYC = ns2cyc(SLP_WAIT_NS, CLK_NS);

  localparam int SU_WR = ns2cyc(WR_CS_NS, CLK_NS);
  localparam int LO_WR = max2(ns2cyc(WR_LO_NS, CLK_NS), ns2cyc(WR_DSU_NS, CLK_NS));
  localparam int HI_WR = max2(max2(ns2cyc(WR_HI_NS, CLK_NS), ns2cyc(WR_DH_NS, CLK_NS)),
                              ns2cyc(WR_CYC_NS, CLK_NS) - LO_WR);
  // sampling happens on the edge that ends the low phase: needs strictly more than the access time
  localparam int SU_ID = ns2cyc(ID_CS_NS, CLK_NS);
  localparam int LO_ID = max2(ns2cyc(ID_LO_NS, CLK_NS), ID_ACC_NS / CLK_NS + 1);
  localparam int HI_ID = max2(ns2cyc(ID_HI_NS, CLK_NS), ns2cyc(ID_CYC_NS, CLK_NS) - LO_ID);
  localparam int SU_FM = ns2cyc(FM_CS_NS, CLK_NS);
  localparam int LO_FM = max2(ns2cyc(FM_LO_NS, CLK_NS), FM_ACC_NS / CLK_NS + 1);
  localparam int HI_FM = max2(ns2cyc(FM_HI_NS, CLK_NS), ns2cyc(FM_CYC_NS, CLK_NS) - LO_FM);
  localparam int HOLD  = ns2cyc(CS_HOLD_NS, CLK_NS);

  logic cmd_ok, slp_ok;

  disp_reset_seq #(
    .RST_CYC(RST_CYC),
    .CMD_CYC(CMD_CYC),
    .SLP_CYC(SLP_CYC)
  ) u_rst (
    .clk      (clk),
    .rst      (rst),
    .lcd_rst_n(lcd_rst_n),
    .cmd_ok   (cmd_ok),
    .slp_ok   (slp_ok)
  );

  disp_xfer_engine #(
    .DW(DW),
    .SU_WR(SU_WR), .LO_WR(LO_WR), .HI_WR(HI_WR),
    .SU_ID(SU_ID), .LO_ID(LO_ID), .HI_ID(HI_ID),
    .SU_FM(SU_FM), .LO_FM(LO_FM), .HI_FM(HI_FM),
    .HOLD(HOLD)
  ) u_eng (
    .clk          (clk),
    .rst          (rst),
    .cmd_ok       (cmd_ok),
    .slp_ok       (slp_ok),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_sleep_out(req_sleep_out),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .cs_n         (lcd_cs_n),
    .dc           (lcd_dc),
    .wr_n         (lcd_wr_n),
    .rd_n         (lcd_rd_n),
    .db_out       (lcd_db_out),
    .db_oe        (lcd_db_oe),
    .db_in        (lcd_db_in)
  );

endmodule

// File: rtl/disp8080_master_chk.sv
module disp8080_master_chk
  import disp8080_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CLK_NS      = 5,
  parameter int CMD_WAIT_NS = 5000000,
  parameter int SLP_WAIT_NS = 120000000
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_sleep_out,
  input logic          rsp_valid,
  input logic          lcd_rst_n,
  input logic          lcd_cs_n,
  input logic          lcd_dc,
  input logic          lcd_wr_n,
  input logic          lcd_rd_n,
  input logic [DW-1:0] lcd_db_out,
  input logic          lcd_db_oe
);
  localparam int CMD_CYC = ns2cyc(CMD_WAIT_NS, CLK_NS);
  localparam int SLP_CYC = ns2cyc(SLP_WAIT_NS, CLK_NS);

  // cycles elapsed since the display reset line was released
  logic [31:0] rel_cnt;
  always_ff @(posedge clk) begin
    if (rst) rel_cnt <= '0;
    else if (lcd_rst_n && rel_cnt != 32'hFFFF_FFFF) rel_cnt <= rel_cnt + 1'b1;
  end

  p_bus_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !lcd_rst_n |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_db_oe && !req_ready));

  p_cmd_lockout_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (rel_cnt >= 32'(CMD_CYC)));

  p_sleep_lockout_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_sleep_out) |-> (rel_cnt >= 32'(SLP_CYC)));

  p_dc_steady_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (!lcd_rd_n && $past(!lcd_rd_n)) |-> $stable(lcd_dc));

  p_wr_fields_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n && $past(!lcd_wr_n)) |-> ($stable(lcd_db_out) && $stable(lcd_dc) && lcd_db_oe));

  p_strobe_inside_cs_r6: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);

  p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(!lcd_wr_n && !lcd_rd_n));

  p_oe_off_before_rd_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_rd_n) |-> (!$past(lcd_db_oe) && !lcd_db_oe));

  p_rsp_at_rd_rise_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(lcd_rd_n));

endmodule

bind disp8080_master disp8080_master_chk #(
  .DW(DW),
  .CLK_NS(CLK_NS),
  .CMD_WAIT_NS(CMD_WAIT_NS),
  .SLP_WAIT_NS(SLP_WAIT_NS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_sleep_out(req_sleep_out),
  .rsp_valid    (rsp_valid),
  .lcd_rst_n    (lcd_rst_n),
  .lcd_cs_n     (lcd_cs_n),
  .lcd_dc       (lcd_dc),
  .lcd_wr_n     (lcd_wr_n),
  .lcd_rd_n     (lcd_rd_n),
  .lcd_db_out   (lcd_db_out),
  .lcd_db_oe    (lcd_db_oe)
);

// File: tb/disp8080_master_test.sv
`timescale 1ns/1ps
module disp8080_master_test;
  localparam int P      = 5;
  localparam int RST_NS = 200;
  localparam int CMD_NS = 2000;
  localparam int SLP_NS = 6000;
  localparam int ID_ACC = 40;
  localparam int FM_ACC = 340;

  function automatic int cyc_of(input int ns);
    return (ns + P - 1) / P;
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_sleep_out = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        lcd_rst_n, lcd_cs_n, lcd_dc, lcd_wr_n, lcd_rd_n, lcd_db_oe;
  logic [15:0] lcd_db_out;
  logic [15:0] lcd_db_in = '0;

  always #2.5 clk = ~clk;

  disp8080_master #(
    .CLK_NS(P), .RST_LOW_NS(RST_NS), .CMD_WAIT_NS(CMD_NS), .SLP_WAIT_NS(SLP_NS)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_sleep_out(req_sleep_out), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lcd_rst_n(lcd_rst_n),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expected transfers and responses
  logic [1:0]  exp_k [0:255];
  logic [15:0] exp_d [0:255];
  logic [15:0] rsp_q [0:255];
  int wp = 0, rp = 0, rsp_wp = 0, rsp_rp = 0, n_reads = 0;
  logic [15:0] disp_val = '0;
  logic [1:0]  disp_kind = 2'd0;

  // display model: drives a wrong word until the access time has passed
  always @(negedge lcd_rd_n) begin
    lcd_db_in = ~disp_val;
    #1;
    if (disp_kind == 2'd3) #(FM_ACC - 1); else #(ID_ACC - 1);
    lcd_db_in = disp_val;
  end

  task automatic send(input logic [1:0] k, input bit slp, input logic [15:0] d, output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_sleep_out = slp; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_k[wp[7:0]] = k; exp_d[wp[7:0]] = d; wp++;
    if (k[1]) begin
      disp_val = d; disp_kind = k;
      rsp_q[rsp_wp[7:0]] = d; rsp_wp++; n_reads++;
    end
    @(posedge clk); #1;
    acc = cyc;
    req_valid = 1'b0; req_sleep_out = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (200) @(negedge clk);
  endtask

  // bus monitor, sampled on the falling clock edge
  logic p_wr = 1, p_rd = 1, p_cs = 1, p_oe = 0, p_rstn = 0;
  int cs_fall = 0, fall_c = 0, rise_c = -1000, last_fall = -1;
  int rst_rise = 0, rst_low = 0, cs_rises = 0, n_rsp = 0;
  logic [1:0]  cur_k = 0;
  logic [15:0] cap_d = 0;
  logic        cap_dc = 0;
  bit          steady = 1;

  function automatic string rd_req(input logic [1:0] k);
    return (k == 2'd3) ? "R8" : "R7";
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (!lcd_rst_n) rst_low++;
      if (lcd_rst_n && !p_rstn) rst_rise = cyc;
      if (p_cs && !lcd_cs_n) begin cs_fall = cyc; last_fall = -1; end
      if (!p_cs && lcd_cs_n) begin
        cs_rises++;
        chk(cyc - rise_c >= cyc_of(10), "R6", "cs hold cycles", cyc - rise_c, cyc_of(10));
      end
      if (p_wr && !lcd_wr_n) begin
        cur_k = exp_k[rp[7:0]];
        chk(!cur_k[1], "R5", "write strobe for kind", cur_k, 0);
        chk(lcd_dc == (cur_k != 2'd0), "R4", "dc on write", lcd_dc, cur_k != 2'd0);
        chk(lcd_db_out == exp_d[rp[7:0]], "R5", "write data", lcd_db_out, exp_d[rp[7:0]]);
        chk(lcd_db_oe, "R5", "oe during write", lcd_db_oe, 1);
        chk(cyc - cs_fall >= cyc_of(15), "R6", "cs setup write", cyc - cs_fall, cyc_of(15));
        if (last_fall >= 0) begin
          chk(cyc - last_fall >= cyc_of(66), "R5", "write cycle", cyc - last_fall, cyc_of(66));
          chk(cyc - rise_c >= cyc_of(15), "R5", "write high", cyc - rise_c, cyc_of(15));
        end
        rp++; last_fall = cyc; fall_c = cyc;
        cap_d = lcd_db_out; cap_dc = lcd_dc; steady = 1;
      end
      if (!p_wr && !lcd_wr_n && (lcd_db_out != cap_d || lcd_dc != cap_dc || !lcd_db_oe)) steady = 0;
      if (!p_wr && lcd_wr_n) begin
        chk(cyc - fall_c >= cyc_of(15), "R5", "write low", cyc - fall_c, cyc_of(15));
        chk(steady, "R5", "write fields steady", steady, 1);
        rise_c = cyc;
      end
      if (p_rd && !lcd_rd_n) begin
        cur_k = exp_k[rp[7:0]];
        chk(cur_k[1], "R9", "read strobe for kind", cur_k, 2);
        chk(lcd_dc == 1'b1, "R4", "dc on read", lcd_dc, 1);
        chk(!lcd_db_oe && !p_oe, "R9", "oe around read fall", {p_oe, lcd_db_oe}, 0);
        chk(cyc - cs_fall >= cyc_of(cur_k == 2'd3 ? 355 : 45), "R6", "cs setup read",
            cyc - cs_fall, cyc_of(cur_k == 2'd3 ? 355 : 45));
        if (last_fall >= 0) begin
          chk(cyc - last_fall >= cyc_of(cur_k == 2'd3 ? 450 : 160), rd_req(cur_k), "read cycle",
              cyc - last_fall, cyc_of(cur_k == 2'd3 ? 450 : 160));
          chk(cyc - rise_c >= cyc_of(90), rd_req(cur_k), "read high", cyc - rise_c, cyc_of(90));
        end
        rp++; last_fall = cyc; fall_c = cyc; cap_dc = lcd_dc; steady = 1;
      end
      if (!p_rd && !lcd_rd_n && (lcd_dc != cap_dc || lcd_db_oe)) steady = 0;
      if (!p_rd && lcd_rd_n) begin
        chk(cyc - fall_c >= cyc_of(cur_k == 2'd3 ? 355 : 45), rd_req(cur_k), "read low",
            cyc - fall_c, cyc_of(cur_k == 2'd3 ? 355 : 45));
        chk(steady, "R4", "dc steady in read", steady, 1);
        rise_c = cyc;
      end
      if (rsp_valid) begin
        n_rsp++;
        chk(!p_rd && lcd_rd_n, "R10", "rsp with rd rise", lcd_rd_n, 1);
        chk(rsp_rdata == rsp_q[rsp_rp[7:0]], rd_req(cur_k), "read data", rsp_rdata, rsp_q[rsp_rp[7:0]]);
        rsp_rp++;
      end
    end
    p_wr = lcd_wr_n; p_rd = lcd_rd_n; p_cs = lcd_cs_n; p_oe = lcd_db_oe; p_rstn = lcd_rst_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int a, b, c0;
    void'($urandom(32'd4321));
    repeat (5) @(negedge clk);
    chk(lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_db_oe && !lcd_rst_n && !req_ready, "R1",
        "reset state", {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_db_oe, lcd_rst_n, req_ready}, 6'b111000);
    rst = 1'b0;
    // R2: plain command, issued long before the lockout ends
    send(2'd0, 1'b0, 16'h0001, a);
    chk(rst_low >= cyc_of(RST_NS), "R1", "reset pulse cycles", rst_low, cyc_of(RST_NS));
    chk(a - rst_rise >= cyc_of(CMD_NS) && a - rst_rise <= cyc_of(CMD_NS) + 3, "R2",
        "command accept delay", a - rst_rise, cyc_of(CMD_NS));
    // R3: sleep-exit command waits for the long lockout
    send(2'd0, 1'b1, 16'h0011, b);
    chk(b - rst_rise >= cyc_of(SLP_NS), "R3", "sleep-exit accept delay", b - rst_rise, cyc_of(SLP_NS));
    wait_idle();
    // directed reads of both kinds
    send(2'd2, 1'b0, 16'h9341, a);
    send(2'd3, 1'b0, 16'hA5C3, a);
    wait_idle();
    // R11: chained same kind keeps cs low; mixed kinds release it
    c0 = cs_rises;
    send(2'd1, 1'b0, 16'h1234, a);
    send(2'd1, 1'b0, 16'h5678, a);
    wait_idle();
    chk(cs_rises - c0 == 1, "R11", "cs rises same kind", cs_rises - c0, 1);
    c0 = cs_rises;
    send(2'd3, 1'b0, 16'h0F0F, a);
    send(2'd3, 1'b0, 16'hF0F0, a);
    wait_idle();
    chk(cs_rises - c0 == 1, "R11", "cs rises chained reads", cs_rises - c0, 1);
    c0 = cs_rises;
    send(2'd1, 1'b0, 16'hCAFE, a);
    send(2'd2, 1'b0, 16'hBEEF, a);
    wait_idle();
    chk(cs_rises - c0 == 2, "R11", "cs rises mixed kind", cs_rises - c0, 2);
    // random mixed traffic, with bursts
    for (int i = 0; i < 50; i++) begin
      logic [1:0] k;
      int burst;
      k = 2'($urandom % 4);
      burst = 1 + int'($urandom % 3);
      for (int j = 0; j < burst; j++) send(k, 1'b0, 16'($urandom), a);
      if ($urandom % 4 == 0) wait_idle();
    end
    wait_idle();
    chk(n_rsp == n_reads, "R10", "response count", n_rsp, n_reads);
    chk(rp == wp, "R5", "strobe count", rp, wp);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule